// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block steps through a three-level transfer that one parameter slot describes. The slot gives the bytes in each array (A), the arrays in each frame (B) and the frames in a block (C), together with the two base addresses and the signed strides. For every array it presents a source address, a destination address and a byte count to the data mover. The data mover accepts each array with a ready/valid handshake. When the last array of the last frame is accepted, the block can raise a one-cycle completion pulse that carries a completion code.

The slot can run in one of two sync modes. In array-sync mode each synchronization event releases one array. In frame-sync mode each event releases all B arrays of a frame, issued back to back. Between arrays in a frame, each side's address moves by its own array stride. When a frame ends, each side returns to the address of that frame's first array and adds its frame stride. Either side can be held at a fixed address, which suits a device FIFO. The B count is reloaded between frames: in array-sync mode from a separate reload value, and in frame-sync mode from the loaded B.

Top module: `dma3d_addr_seq`

## Requirements
- R1: After reset, `arr_valid` and `done_pulse` stay low until a slot is loaded and an event arrives.
- R2: Events that arrive while no slot is active are ignored and issue no array. No slot is active after reset, or after the final array of a slot has been accepted.
- R3: In array-sync mode (`load_ab_sync` = 0), an event sampled while the slot waits raises `arr_valid` in the next cycle. The array's addresses and byte count stay stable until `arr_ready` is sampled high, and each event releases exactly one array.
- R4: In frame-sync mode (`load_ab_sync` = 1), one event releases B arrays in a row, one per handshake. After that the block waits for the next event.
- R5: After each accepted array that is not the last of its frame, each side's address grows by its sign-extended 16-bit array stride. The source stride is in bits 15:0 of `load_arr_idx` and the destination stride is in bits 31:16.
- R6: After the last array of a frame, each side's next address is that frame's first-array address plus the sign-extended frame stride. The source stride is in bits 15:0 of `load_frm_idx` and the destination stride is in bits 31:16.
- R7: C counts frames. Between frames, B reloads from `load_b_rld` in array-sync mode and from the loaded B in frame-sync mode.
- R8: A side whose constant flag (`load_src_const` or `load_dst_const`) is set keeps its base address for every array of the block.
- R9: `arr_bytes` equals A, taken from bits 15:0 of `load_ab_cnt`. B is taken from bits 31:16 of `load_ab_cnt`.
- R10: In the cycle after the final array is accepted, `done_pulse` is high for exactly one cycle and `done_code` holds the slot's code, but only if `load_done_en` was set. With the flag clear there is no pulse. Either way the block goes idle.
- R11: An event that arrives while an array is still outstanding is remembered, one deep, and starts the next array or frame without waiting. Any further events before that one is used are lost.
- R12: `load_valid` takes effect in any state. It restarts the walk from the new slot, drops the outstanding array and clears a remembered event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_valid | input | 1 | Loads the slot fields below in this cycle |
| load_src_addr | input | ADDR_W | Source base address |
| load_dst_addr | input | ADDR_W | Destination base address |
| load_ab_cnt | input | 2*CNT_W | A in bits 15:0, B in bits 31:16 |
| load_c_cnt | input | CNT_W | Frames per block (C) |
| load_b_rld | input | CNT_W | B reload value for array-sync mode |
| load_arr_idx | input | 2*IDX_W | Array strides: source 15:0, destination 31:16 |
| load_frm_idx | input | 2*IDX_W | Frame strides: source 15:0, destination 31:16 |
| load_src_const | input | 1 | Hold the source address fixed |
| load_dst_const | input | 1 | Hold the destination address fixed |
| load_ab_sync | input | 1 | 1 = frame per event, 0 = array per event |
| load_done_en | input | 1 | Enables the completion pulse |
| load_done_code | input | CODE_W | Completion code reported on done |
| evt | input | 1 | Synchronization event |
| arr_valid | output | 1 | An array request is presented |
| arr_ready | input | 1 | Data mover accepts the presented array |
| arr_src | output | ADDR_W | Source address of the array |
| arr_dst | output | ADDR_W | Destination address of the array |
| arr_bytes | output | CNT_W | Byte count of the array |
| done_pulse | output | 1 | One-cycle completion pulse |
| done_code | output | CODE_W | Completion code, valid with done_pulse |

## Verification
Properties check the following on every cycle. A presented array keeps its addresses and count until it is accepted. A new slot load removes any presented array. A constant side never moves when an array is accepted. The completion pulse lasts one cycle, follows an accepted array, leaves the block idle and carries the code that was loaded. The stride arithmetic, the frame rewind, the choice of B reload value, the remembered event and the gating by the enable flag depend on whole sequences of events and handshakes. Only the bench's behavioural model can show these, since it tracks every array of each scenario and compares the ports against them cycle by cycle.

// File: rtl/dma3d_pkg.sv
// Shared types for the three-dimensional address sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dma3d_pkg;

    // Sequencer phase: no slot, slot waiting for an event, array presented.
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_WAIT  = 2'd1,
        SQ_ISSUE = 2'd2
    } sq_state_e;

    // Index of each address side inside the generate loop of the top.
    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;
    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/dma3d_addr_walk.sv
// One address side (source or destination) of the sequencer.
// Keeps the address of the current array and of the first array of the
// current frame. On each accepted array it adds the array stride, or at a
// frame end it rewinds to the frame start plus the frame stride.
// Assumes: ADDR_W > IDX_W; step and frame_end come from the controller
// and are single-cycle qualified with the handshake.
module dma3d_addr_walk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic              ld_const,
    input  logic [IDX_W-1:0]  ld_arr_idx,
    input  logic [IDX_W-1:0]  ld_frm_idx,
    input  logic              step,
    input  logic              frame_end,
    output logic [ADDR_W-1:0] addr
);

    localparam int EXT_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] fstart_q;
    logic [ADDR_W-1:0] arr_off_q;
    logic [ADDR_W-1:0] frm_off_q;
    logic              const_q;
    logic [ADDR_W-1:0] next_fstart;

    // Frame-start address of the following frame.
    always_comb begin
        next_fstart = fstart_q + frm_off_q;
    end

    // Address registers: capture on load, advance on each accepted array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= '0;
            fstart_q  <= '0;
            arr_off_q <= '0;
            frm_off_q <= '0;
            const_q   <= 1'b0;
        end else if (load) begin
            cur_q     <= ld_base;
            fstart_q  <= ld_base;
            arr_off_q <= {{EXT_W{ld_arr_idx[IDX_W-1]}}, ld_arr_idx};
            frm_off_q <= {{EXT_W{ld_frm_idx[IDX_W-1]}}, ld_frm_idx};
            const_q   <= ld_const;
        end else if (step && !const_q) begin
            if (frame_end) begin
                fstart_q <= next_fstart;
                cur_q    <= next_fstart;
            end else begin
                cur_q <= cur_q + arr_off_q;
            end
        end
    end

    assign addr = cur_q;

endmodule

// File: rtl/dma3d_seq_ctrl.sv
// Control side of the sequencer: counts arrays in a frame and frames in a
// block, reacts to events in either sync mode, keeps one remembered event,
// drives the array handshake and the completion pulse.
// Assumes: loaded A, B, C and the B reload value are all at least 1.
module dma3d_seq_ctrl
    import dma3d_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  ld_a,
    input  logic [CNT_W-1:0]  ld_b,
    input  logic [CNT_W-1:0]  ld_c,
    input  logic [CNT_W-1:0]  ld_rld,
    input  logic              ld_ab,
    input  logic              ld_en,
    input  logic [CODE_W-1:0] ld_code,
    input  logic              evt,
    input  logic              arr_ready,
    output logic              arr_valid,
    output logic [CNT_W-1:0]  arr_bytes,
    output logic              step,
    output logic              frame_end,
    output logic              done_pulse,
    output logic [CODE_W-1:0] done_code
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    sq_state_e         state_q;
    logic              pend_q;
    logic [CNT_W-1:0]  a_q;
    logic [CNT_W-1:0]  b_left_q;
    logic [CNT_W-1:0]  c_left_q;
    logic [CNT_W-1:0]  b_init_q;
    logic [CNT_W-1:0]  b_rld_q;
    logic              ab_q;
    logic              en_q;
    logic [CODE_W-1:0] code_q;
    logic              done_q;
    logic              hs;
    logic              last_arr;
    logic              last_frm;
    logic [CNT_W-1:0]  b_next_frame;

    // Handshake and end-of-dimension decode.
    always_comb begin
        hs           = (state_q == SQ_ISSUE) && arr_ready;
        last_arr     = (b_left_q == CNT_ONE);
        last_frm     = (c_left_q == CNT_ONE);
        b_next_frame = ab_q ? b_init_q : b_rld_q;
    end

    // Slot configuration captured at load time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_init_q <= '0;
            b_rld_q  <= '0;
            ab_q     <= 1'b0;
            en_q     <= 1'b0;
            code_q   <= '0;
        end else if (load) begin
            a_q      <= ld_a;
            b_init_q <= ld_b;
            b_rld_q  <= ld_rld;
            ab_q     <= ld_ab;
            en_q     <= ld_en;
            code_q   <= ld_code;
        end
    end

    // Phase, remembered event and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            pend_q  <= 1'b0;
            done_q  <= 1'b0;
        end else if (load) begin
            state_q <= SQ_WAIT;
            pend_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_WAIT: begin
                    if (evt || pend_q) begin
                        state_q <= SQ_ISSUE;
                        pend_q  <= 1'b0;
                    end
                end
                SQ_ISSUE: begin
                    if (evt) begin
                        pend_q <= 1'b1;
                    end
                    if (hs) begin
                        if (last_arr && last_frm) begin
                            state_q <= SQ_IDLE;
                            pend_q  <= 1'b0;
                            done_q  <= en_q;
                        end else if (last_arr || !ab_q) begin
                            state_q <= SQ_WAIT;
                        end
                    end
                end
                default: begin
                    state_q <= SQ_IDLE;
                end
            endcase
        end
    end

    // Array and frame counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_left_q <= '0;
            c_left_q <= '0;
        end else if (load) begin
            b_left_q <= ld_b;
            c_left_q <= ld_c;
        end else if (hs) begin
            if (last_arr) begin
                b_left_q <= b_next_frame;
                c_left_q <= c_left_q - CNT_ONE;
            end else begin
                b_left_q <= b_left_q - CNT_ONE;
            end
        end
    end

    assign arr_valid  = (state_q == SQ_ISSUE);
    assign arr_bytes  = a_q;
    assign step       = hs && !load;
    assign frame_end  = last_arr;
    assign done_pulse = done_q;
    assign done_code  = code_q;

endmodule

// File: rtl/dma3d_addr_seq.sv
// Top of the three-dimensional address sequencer. Splits the packed slot
// words into their halfwords, instantiates the controller and one address
// walker per side.
// Assumes: a slot load is a single-cycle pulse with all fields valid.
module dma3d_addr_seq
    import dma3d_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int IDX_W  = 16,
    parameter int CODE_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_valid,
    input  logic [ADDR_W-1:0]    load_src_addr,
    input  logic [ADDR_W-1:0]    load_dst_addr,
    input  logic [2*CNT_W-1:0]   load_ab_cnt,
    input  logic [CNT_W-1:0]     load_c_cnt,
    input  logic [CNT_W-1:0]     load_b_rld,
    input  logic [2*IDX_W-1:0]   load_arr_idx,
    input  logic [2*IDX_W-1:0]   load_frm_idx,
    input  logic                 load_src_const,
    input  logic                 load_dst_const,
    input  logic                 load_ab_sync,
    input  logic                 load_done_en,
    input  logic [CODE_W-1:0]    load_done_code,
    input  logic                 evt,
    output logic                 arr_valid,
    input  logic                 arr_ready,
    output logic [ADDR_W-1:0]    arr_src,
    output logic [ADDR_W-1:0]    arr_dst,
    output logic [CNT_W-1:0]     arr_bytes,
    output logic                 done_pulse,
    output logic [CODE_W-1:0]    done_code
);

    logic              step;
    logic              frame_end;
    logic [ADDR_W-1:0] side_base  [NUM_SIDES];
    logic              side_const [NUM_SIDES];
    logic [IDX_W-1:0]  side_aidx  [NUM_SIDES];
    logic [IDX_W-1:0]  side_fidx  [NUM_SIDES];
    logic [ADDR_W-1:0] side_addr  [NUM_SIDES];

    // Route the slot fields of each side to its walker.
    always_comb begin
        side_base[SIDE_SRC]  = load_src_addr;
        side_base[SIDE_DST]  = load_dst_addr;
        side_const[SIDE_SRC] = load_src_const;
        side_const[SIDE_DST] = load_dst_const;
        side_aidx[SIDE_SRC]  = load_arr_idx[IDX_W-1:0];
        side_aidx[SIDE_DST]  = load_arr_idx[2*IDX_W-1:IDX_W];
        side_fidx[SIDE_SRC]  = load_frm_idx[IDX_W-1:0];
        side_fidx[SIDE_DST]  = load_frm_idx[2*IDX_W-1:IDX_W];
    end

    dma3d_seq_ctrl #(
        .CNT_W  (CNT_W),
        .CODE_W (CODE_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_valid),
        .ld_a       (load_ab_cnt[CNT_W-1:0]),
        .ld_b       (load_ab_cnt[2*CNT_W-1:CNT_W]),
        .ld_c       (load_c_cnt),
        .ld_rld     (load_b_rld),
        .ld_ab      (load_ab_sync),
        .ld_en      (load_done_en),
        .ld_code    (load_done_code),
        .evt        (evt),
        .arr_ready  (arr_ready),
        .arr_valid  (arr_valid),
        .arr_bytes  (arr_bytes),
        .step       (step),
        .frame_end  (frame_end),
        .done_pulse (done_pulse),
        .done_code  (done_code)
    );

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        dma3d_addr_walk #(
            .ADDR_W (ADDR_W),
            .IDX_W  (IDX_W)
        ) walk_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load_valid),
            .ld_base    (side_base[s]),
            .ld_const   (side_const[s]),
            .ld_arr_idx (side_aidx[s]),
            .ld_frm_idx (side_fidx[s]),
            .step       (step),
            .frame_end  (frame_end),
            .addr       (side_addr[s])
        );
    end

    assign arr_src = side_addr[SIDE_SRC];
    assign arr_dst = side_addr[SIDE_DST];

endmodule

// File: rtl/dma3d_addr_seq_chk.sv
// Property checker for the address sequencer, attached by bind.
// Assumes: the same parameters as the top it is bound to.
module dma3d_addr_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_valid,
    input logic              load_src_const,
    input logic              load_dst_const,
    input logic [CODE_W-1:0] load_done_code,
    input logic              arr_valid,
    input logic              arr_ready,
    input logic [ADDR_W-1:0] arr_src,
    input logic [ADDR_W-1:0] arr_dst,
    input logic [CNT_W-1:0]  arr_bytes,
    input logic              done_pulse,
    input logic [CODE_W-1:0] done_code
);

    logic              sc_lat;
    logic              dc_lat;
    logic [CODE_W-1:0] code_lat;

    // Slot settings seen at the ports, kept for the properties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_lat   <= 1'b0;
            dc_lat   <= 1'b0;
            code_lat <= '0;
        end else if (load_valid) begin
            sc_lat   <= load_src_const;
            dc_lat   <= load_dst_const;
            code_lat <= load_done_code;
        end
    end

    // R3: a presented array is held until accepted
    a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && !arr_ready && !load_valid) |=>
            (arr_valid && $stable(arr_src) && $stable(arr_dst) && $stable(arr_bytes)));

    // R8: constant sides do not move on acceptance
    a_r8_src_const_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && arr_ready && !load_valid && sc_lat) |=> $stable(arr_src));

    a_r8_dst_const_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && arr_ready && !load_valid && dc_lat) |=> $stable(arr_dst));

    // R10: completion follows an accepted array
    a_r10_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(arr_valid && arr_ready && !load_valid));

    // R10: completion lasts one cycle
    a_r10_one_cycle_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R10: idle once complete
    a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !arr_valid);

    // R10: code is the one loaded with the slot
    a_r10_code_matches_slot: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (done_code == code_lat));

    // R12: a load drops any presented array
    a_r12_load_drops_array: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> !arr_valid);

endmodule

bind dma3d_addr_seq dma3d_addr_seq_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .CODE_W (CODE_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .load_valid     (load_valid),
    .load_src_const (load_src_const),
    .load_dst_const (load_dst_const),
    .load_done_code (load_done_code),
    .arr_valid      (arr_valid),
    .arr_ready      (arr_ready),
    .arr_src        (arr_src),
    .arr_dst        (arr_dst),
    .arr_bytes      (arr_bytes),
    .done_pulse     (done_pulse),
    .done_code      (done_code)
);

// File: tb/dma3d_addr_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the ports every cycle,
// plus scenario checks on counts and addresses.
module dma3d_addr_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0;
    logic [31:0] load_src_addr = '0;
    logic [31:0] load_dst_addr = '0;
    logic [31:0] load_ab_cnt = '0;
    logic [15:0] load_c_cnt = '0;
    logic [15:0] load_b_rld = '0;
    logic [31:0] load_arr_idx = '0;
    logic [31:0] load_frm_idx = '0;
    logic        load_src_const = 1'b0;
    logic        load_dst_const = 1'b0;
    logic        load_ab_sync = 1'b0;
    logic        load_done_en = 1'b0;
    logic [5:0]  load_done_code = '0;
    logic        evt = 1'b0;
    logic        arr_valid;
    logic        arr_ready = 1'b1;
    logic [31:0] arr_src;
    logic [31:0] arr_dst;
    logic [15:0] arr_bytes;
    logic        done_pulse;
    logic [5:0]  done_code;

    dma3d_addr_seq dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .load_valid     (load_valid),
        .load_src_addr  (load_src_addr),
        .load_dst_addr  (load_dst_addr),
        .load_ab_cnt    (load_ab_cnt),
        .load_c_cnt     (load_c_cnt),
        .load_b_rld     (load_b_rld),
        .load_arr_idx   (load_arr_idx),
        .load_frm_idx   (load_frm_idx),
        .load_src_const (load_src_const),
        .load_dst_const (load_dst_const),
        .load_ab_sync   (load_ab_sync),
        .load_done_en   (load_done_en),
        .load_done_code (load_done_code),
        .evt            (evt),
        .arr_valid      (arr_valid),
        .arr_ready      (arr_ready),
        .arr_src        (arr_src),
        .arr_dst        (arr_dst),
        .arr_bytes      (arr_bytes),
        .done_pulse     (done_pulse),
        .done_code      (done_code)
    );

    always #2 clk = ~clk;

    int    vectors = 0;
    int    fails = 0;
    int    acks = 0;
    int    dones = 0;
    int    last_code = -1;
    int    rdy_mode = 0;
    string tag = "R1";

    // Reference model state: 0 no slot, 1 waiting, 2 array presented.
    int          m_state = 0;
    bit          m_pend = 0;
    bit          m_done = 0;
    int          m_code = 0;
    int          m_a = 0, m_b = 0, m_c = 0, m_b0 = 0, m_rld = 0;
    bit          m_ab = 0, m_en = 0, m_sc = 0, m_dc = 0;
    logic [31:0] m_src = 0, m_dst = 0, m_fs = 0, m_fd = 0;
    logic [31:0] m_ais = 0, m_aid = 0, m_fis = 0, m_fid = 0;

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    // Reference model, advanced on each rising edge from the port inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_pend = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (load_valid) begin
                m_state = 1; m_pend = 0;
                m_a = int'(load_ab_cnt[15:0]); m_b0 = int'(load_ab_cnt[31:16]);
                m_b = m_b0; m_c = int'(load_c_cnt); m_rld = int'(load_b_rld);
                m_src = load_src_addr; m_fs = load_src_addr;
                m_dst = load_dst_addr; m_fd = load_dst_addr;
                m_ais = sx(load_arr_idx[15:0]); m_aid = sx(load_arr_idx[31:16]);
                m_fis = sx(load_frm_idx[15:0]); m_fid = sx(load_frm_idx[31:16]);
                m_sc = load_src_const; m_dc = load_dst_const;
                m_ab = load_ab_sync; m_en = load_done_en; m_code = int'(load_done_code);
            end else if (m_state == 1) begin
                if (evt || m_pend) begin m_state = 2; m_pend = 0; end
            end else if (m_state == 2) begin
                if (evt) m_pend = 1;
                if (arr_ready) begin
                    if (m_b == 1) begin
                        if (!m_sc) begin m_fs = m_fs + m_fis; m_src = m_fs; end
                        if (!m_dc) begin m_fd = m_fd + m_fid; m_dst = m_fd; end
                        m_c = m_c - 1;
                        m_b = m_ab ? m_b0 : m_rld;
                        if (m_c == 0) begin
                            m_state = 0; m_pend = 0; m_done = m_en;
                        end else begin
                            m_state = 1;
                        end
                    end else begin
                        if (!m_sc) m_src = m_src + m_ais;
                        if (!m_dc) m_dst = m_dst + m_aid;
                        m_b = m_b - 1;
                        if (!m_ab) m_state = 1;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison of every output against the model.
    task automatic compare();
        chk(arr_valid == (m_state == 2), "arr_valid", arr_valid, m_state == 2);
        if (m_state == 2) begin
            chk(arr_src == m_src, "arr_src", arr_src, m_src);
            chk(arr_dst == m_dst, "arr_dst", arr_dst, m_dst);
            chk(int'(arr_bytes) == m_a, "arr_bytes", arr_bytes, m_a);
        end
        chk(done_pulse == m_done, "done_pulse", done_pulse, m_done);
        if (done_pulse) begin
            dones++;
            last_code = int'(done_code);
            chk(int'(done_code) == m_code, "done_code", done_code, m_code);
        end
    endtask

    task automatic tick();
        bit hs_pre;
        hs_pre = arr_valid && arr_ready;
        @(negedge clk);
        if (hs_pre && rst_n) acks++;
        compare();
        if (rdy_mode == 0) arr_ready = 1'b1;
        else if (rdy_mode == 1) arr_ready = ~arr_ready;
        else arr_ready = 1'b0;
    endtask

    task automatic load_slot(input logic [31:0] s, input logic [31:0] d,
                             input int a, input int b, input int c, input int rld,
                             input logic [15:0] ais, input logic [15:0] aid,
                             input logic [15:0] fis, input logic [15:0] fid,
                             input bit sc, input bit dc, input bit ab,
                             input bit en, input int code);
        load_src_addr = s; load_dst_addr = d;
        load_ab_cnt = {16'(b), 16'(a)}; load_c_cnt = 16'(c); load_b_rld = 16'(rld);
        load_arr_idx = {aid, ais}; load_frm_idx = {fid, fis};
        load_src_const = sc; load_dst_const = dc; load_ab_sync = ab;
        load_done_en = en; load_done_code = 6'(code);
        load_valid = 1'b1;
        tick();
        load_valid = 1'b0;
    endtask

    task automatic fire();
        evt = 1'b1;
        tick();
        evt = 1'b0;
    endtask

    task automatic settle();
        for (int i = 0; i < 200; i++) begin
            if (m_state != 2 && !m_pend) break;
            tick();
        end
    endtask

    task automatic reset_counts();
        acks = 0; dones = 0; last_code = -1;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(!arr_valid, "R1 arr_valid after reset", arr_valid, 0);
        chk(!done_pulse, "R1 done after reset", done_pulse, 0);

        // R2: events without a slot
        tag = "R2";
        reset_counts();
        repeat (3) fire();
        tick();
        chk(acks == 0 && !arr_valid, "R2 arrays without slot", acks, 0);

        // R3 R5 R6 R7 R9: array-sync walk, B=3 C=2 reload 2
        tag = "R3";
        reset_counts();
        load_slot(32'h1000, 32'h8000, 4, 3, 2, 2, 16'd4, 16'd8, 16'd100, 16'hFFF0,
                  0, 0, 0, 1, 5);
        tick();
        chk(!arr_valid, "R3 no array before event", arr_valid, 0);
        fire();
        chk(arr_valid && arr_src == 32'h1000, "R3 first array src", arr_src, 32'h1000);
        tag = "R9";
        chk(arr_bytes == 16'd4, "R9 byte count", arr_bytes, 4);
        settle();
        tag = "R5";
        fire();
        chk(arr_src == 32'h1004 && arr_dst == 32'h8008, "R5 second array dst", arr_dst, 32'h8008);
        settle();
        fire(); settle();
        tag = "R6";
        fire();
        chk(arr_src == 32'h1064, "R6 frame two src", arr_src, 32'h1064);
        chk(arr_dst == 32'h7FF0, "R6 frame two dst", arr_dst, 32'h7FF0);
        settle();
        tag = "R7";
        chk(dones == 0, "R7 not done after four arrays", dones, 0);
        fire(); settle(); tick();
        chk(acks == 5, "R7 array count with reload", acks, 5);
        tag = "R10";
        chk(dones == 1 && last_code == 5, "R10 done code", last_code, 5);

        // R4 R7: frame-sync, toggling ready, reload value ignored
        tag = "R4";
        reset_counts();
        rdy_mode = 1;
        load_slot(32'h0200, 32'h0900, 8, 3, 2, 1, 16'd8, 16'hFFF8, 16'h40, 16'h40,
                  0, 0, 1, 1, 9);
        fire(); settle(); tick();
        chk(acks == 3, "R4 arrays from one event", acks, 3);
        tag = "R7";
        fire(); settle(); tick();
        chk(acks == 6 && dones == 1, "R7 frame-sync reload from B", acks, 6);
        rdy_mode = 0;

        // R8: constant source
        tag = "R8";
        reset_counts();
        load_slot(32'h4000, 32'h5000, 2, 2, 2, 2, 16'd2, 16'd2, 16'd16, 16'd16,
                  1, 0, 1, 1, 1);
        fire();
        chk(arr_src == 32'h4000, "R8 const src first", arr_src, 32'h4000);
        settle();
        fire();
        chk(arr_src == 32'h4000, "R8 const src frame two", arr_src, 32'h4000);
        chk(arr_dst == 32'h5010, "R8 moving dst frame two", arr_dst, 32'h5010);
        settle(); tick();

        // R11: remembered event, extra events lost
        tag = "R11";
        reset_counts();
        rdy_mode = 2; arr_ready = 1'b0;
        load_slot(32'h100, 32'h200, 1, 4, 1, 4, 16'd1, 16'd1, 16'd0, 16'd0,
                  0, 0, 0, 1, 3);
        fire(); tick(); fire(); fire();
        rdy_mode = 0; arr_ready = 1'b1;
        settle(); tick();
        chk(acks == 2, "R11 one remembered event", acks, 2);
        fire(); settle(); fire(); settle(); tick();
        chk(acks == 4 && dones == 1, "R11 block completes", acks, 4);

        // R12: reload in flight
        tag = "R12";
        reset_counts();
        load_slot(32'h2000, 32'h2100, 4, 2, 2, 2, 16'd4, 16'd4, 16'd0, 16'd0,
                  0, 0, 0, 1, 2);
        fire(); settle();
        rdy_mode = 2; arr_ready = 1'b0;
        fire(); tick(); fire();
        load_slot(32'h3000, 32'h4000, 16, 1, 1, 1, 16'd0, 16'd0, 16'd0, 16'd0,
                  0, 0, 0, 1, 7);
        repeat (3) tick();
        chk(!arr_valid, "R12 pending dropped by load", arr_valid, 0);
        rdy_mode = 0; arr_ready = 1'b1;
        fire();
        chk(arr_src == 32'h3000, "R12 new slot src", arr_src, 32'h3000);
        settle(); tick();
        chk(dones == 1 && last_code == 7, "R12 new slot completes", last_code, 7);

        // R10 R2: completion disabled, then events after completion
        tag = "R10";
        reset_counts();
        load_slot(32'h10, 32'h20, 1, 1, 1, 1, 16'd0, 16'd0, 16'd0, 16'd0,
                  0, 0, 0, 0, 4);
        fire(); settle(); repeat (2) tick();
        chk(acks == 1 && dones == 0, "R10 no pulse when disabled", dones, 0);
        tag = "R2";
        fire(); repeat (2) tick();
        chk(acks == 1 && !arr_valid, "R2 events after completion", acks, 1);

        summary();
        $finish;
    end

endmodule